// File: doc/BRIEF.md
# Fractional PLL Frequency Ramp Controller

This block moves the fractional part of a transceiver PLL feedback divider from its present value to a requested one without the PLL losing lock. The fraction is a 22-bit unsigned count k, and the fractional feedback value is k / 2^22; for example, k = 2097152 means 0.5. The block is a master on a simple memory-mapped register bus. On a start pulse it reads the current k field. It then walks the field toward the target in steps no larger than a configured maximum. Each new value is committed by driving a separate strobe bit low, then high, then low again. A configured number of clock cycles must pass between one commit and the next step.

The caller converts its ppm or kHz step limit into a k increment outside the block. One k LSB is worth (1/2^22)/(K+M)·10^6 ppm. The caller also supplies the reprogram threshold in k counts. When the requested change is larger than that threshold, the block does not ramp. It holds the PLL in reset, rewrites the k field and the integer M field, and then releases the reset.

Top module: `frac_ramp_ctrl`

## Requirements
- R1: While reset is held and after reset is released, busy_o, pll_rst_o, bus_read_o and bus_write_o are all low.
- R2: The register base address is 0x44000 + lane·0x8000 + pll·0x100, where pll code 0/1/2 selects the slow, medium or fast PLL. The k register sits at the base, the M register at base+0x4, and the strobe register at base+0xC. No other address is accessed.
- R3: k occupies bits [30:9] of its register. Every write to that register keeps bits 31 and [8:0] equal to the values read at start.
- R4: Each k step is committed by a write with strobe bit 17 set, followed by a write with bit 17 clear. Both writes keep the other bits of the strobe register as read. Bit 17 is clear when the run ends.
- R5: Each committed step changes k by at most max_step_i. The last step lands exactly on target_k_i, and a ramp over distance d makes exactly ceil(d/max_step_i) commits.
- R6: From the acceptance of the strobe-clearing write to the acceptance of the next k write, at least min_gap_i clock cycles pass.
- R7: When |target − current| exceeds reprog_lim_i, pll_rst_o is raised first. The block then writes the target k and target_m_i into M bits [8:0], keeping the other bits of both registers. It issues no strobe commit, and pll_rst_o is low again before busy_o falls.
- R8: busy_o rises in the cycle after an accepted start_i and stays high until the last bus access has completed. A start_i pulse while busy is ignored.
- R9: At most one of read and write is asserted at a time. While bus_waitreq_i holds an access, the address, data and command stay unchanged. Read data is taken when bus_rvalid_i is high.
- R10: When the target equals the current k, the run ends after the two reads, with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; the request inputs are latched on it |
| lane_i | input | 2 | Lane within the quad (0..3) |
| pll_sel_i | input | 2 | PLL select: 0 slow, 1 medium, 2 fast |
| target_k_i | input | 22 | Requested fraction count |
| target_m_i | input | 9 | Integer M value used by a reprogram |
| max_step_i | input | 22 | Largest k change per step (0 is treated as 1) |
| min_gap_i | input | 16 | Minimum cycles between steps |
| reprog_lim_i | input | 22 | Largest change that may be ramped |
| busy_o | output | 1 | Run in progress |
| pll_rst_o | output | 1 | PLL reset hold during a reprogram |
| bus_addr_o | output | 20 | Register address |
| bus_read_o | output | 1 | Read command |
| bus_write_o | output | 1 | Write command |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data |
| bus_rvalid_i | input | 1 | Read data valid |
| bus_waitreq_i | input | 1 | Slave stall |

## Verification
The assertions assume that the slave answers every accepted read with exactly one rvalid pulse. They also assume that no other master changes the three registers during a run, and that the request inputs are held steady from start until busy_o falls. The bench slave stalls one cycle in three and returns read data one cycle after acceptance. The bench holds each request stable for the whole run and gives no bus master other than the block access to the registers. The one start issued during a run is there only to check that it is ignored.

// File: rtl/frac_ramp_pkg.sv
package frac_ramp_pkg;
  localparam int unsigned ADDR_W  = 20;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned K_W     = 22;
  localparam int unsigned K_LSB   = 9;
  localparam int unsigned M_W     = 9;
  localparam int unsigned STB_BIT = 17;

  localparam logic [ADDR_W-1:0] BASE0   = 20'h44000;
  localparam logic [ADDR_W-1:0] STB_OFS = 20'h0000C;
  localparam logic [ADDR_W-1:0] M_OFS   = 20'h00004;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_K, ST_RD_S, ST_PLAN, ST_WAIT, ST_WR_K, ST_STB_HI,
    ST_STB_LO, ST_RST_ON, ST_RP_K, ST_RD_M, ST_WR_M, ST_RST_OFF
  } ramp_st_e;

  function automatic logic [ADDR_W-1:0] reg_base(input logic [1:0] lane,
                                                 input logic [1:0] pll);
    logic [1:0] p;
    p = (pll == 2'd3) ? 2'd2 : pll;
    return BASE0 + {3'b0, lane, 15'b0} + {10'b0, p, 8'b0};
  endfunction

  function automatic logic [DATA_W-1:0] put_k(input logic [DATA_W-1:0] w,
                                              input logic [K_W-1:0] k);
    logic [DATA_W-1:0] r;
    r = w;
    r[K_LSB +: K_W] = k;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] put_m(input logic [DATA_W-1:0] w,
                                              input logic [M_W-1:0] m);
    logic [DATA_W-1:0] r;
    r = w;
    r[M_W-1:0] = m;
    return r;
  endfunction
endpackage

// File: rtl/frac_step_plan.sv
module frac_step_plan #(
  parameter int unsigned K_W = 22
) (
  input  logic [K_W-1:0] cur_i,
  input  logic [K_W-1:0] tgt_i,
  input  logic [K_W-1:0] max_step_i,
  input  logic [K_W-1:0] limit_i,
  output logic [K_W-1:0] next_o,
  output logic           zero_o,
  output logic           too_big_o
);
  logic           up;
  logic [K_W-1:0] mag, lim_step, step;

  always_comb begin
    up        = tgt_i > cur_i;
    mag       = up ? (tgt_i - cur_i) : (cur_i - tgt_i);
    lim_step  = (max_step_i == '0) ? K_W'(1) : max_step_i;
    step      = (mag > lim_step) ? lim_step : mag;  // clip last step
    next_o    = up ? (cur_i + step) : (cur_i - step);
    zero_o    = (mag == '0);
    too_big_o = (mag > limit_i);
  end
endmodule

// File: rtl/frac_gap_timer.sv
module frac_gap_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/frac_bus_master.sv
module frac_bus_master #(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          req_wr_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] addr_o,
  output logic          read_o,
  output logic          write_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          rvalid_i,
  input  logic          waitreq_i
);
  typedef enum logic [1:0] {B_IDLE, B_CMD, B_RWAIT} bst_e;
  bst_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      addr_o  <= '0;
      read_o  <= 1'b0;
      write_o <= 1'b0;
      wdata_o <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        B_IDLE: if (req_i) begin
          addr_o  <= req_addr_i;
          wdata_o <= req_wdata_i;
          write_o <= req_wr_i;
          read_o  <= !req_wr_i;
          st_q    <= B_CMD;
        end
        B_CMD: if (!waitreq_i) begin
          read_o  <= 1'b0;
          write_o <= 1'b0;
          if (write_o) begin
            done_o <= 1'b1;
            st_q   <= B_IDLE;
          end else begin
            st_q   <= B_RWAIT;
          end
        end
        B_RWAIT: if (rvalid_i) begin
          rdata_o <= rdata_i;
          done_o  <= 1'b1;
          st_q    <= B_IDLE;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign idle_o = (st_q == B_IDLE);
endmodule

// File: rtl/frac_ramp_ctrl.sv
module frac_ramp_ctrl
  import frac_ramp_pkg::*;
#(
  parameter int unsigned GAP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        lane_i,
  input  logic [1:0]        pll_sel_i,
  input  logic [K_W-1:0]    target_k_i,
  input  logic [M_W-1:0]    target_m_i,
  input  logic [K_W-1:0]    max_step_i,
  input  logic [GAP_W-1:0]  min_gap_i,
  input  logic [K_W-1:0]    reprog_lim_i,
  output logic              busy_o,
  output logic              pll_rst_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_read_o,
  output logic              bus_write_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rvalid_i,
  input  logic              bus_waitreq_i
);
  ramp_st_e          st_q;
  logic [K_W-1:0]    tgt_q, cur_q, nxt_q, max_q, lim_q;
  logic [M_W-1:0]    m_q;
  logic [GAP_W-1:0]  gap_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] kword_q, sword_q, mword_q;
  logic              rst_q, pend_q;

  logic              op_act, op_wr, req, bm_idle, bm_done;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata, bm_rdata;
  logic [K_W-1:0]    plan_next;
  logic              plan_zero, plan_big, tmr_load, tmr_done;

  frac_step_plan #(.K_W(K_W)) u_plan (
    .cur_i(cur_q), .tgt_i(tgt_q), .max_step_i(max_q), .limit_i(lim_q),
    .next_o(plan_next), .zero_o(plan_zero), .too_big_o(plan_big)
  );

  assign tmr_load = (st_q == ST_STB_LO) && bm_done;

  frac_gap_timer #(.W(GAP_W)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(gap_q),
    .done_o(tmr_done)
  );

  always_comb begin
    op_act   = 1'b1;
    op_wr    = 1'b0;
    op_addr  = base_q;
    op_wdata = '0;
    unique case (st_q)
      ST_RD_K:   ;
      ST_RD_S:   op_addr = base_q + STB_OFS;
      ST_RD_M:   op_addr = base_q + M_OFS;
      ST_WR_K: begin
        op_wr = 1'b1; op_wdata = put_k(kword_q, nxt_q);
      end
      ST_RP_K: begin
        op_wr = 1'b1; op_wdata = put_k(kword_q, tgt_q);
      end
      ST_STB_HI: begin
        op_wr = 1'b1; op_addr = base_q + STB_OFS;
        op_wdata = sword_q | (DATA_W'(1) << STB_BIT);
      end
      ST_STB_LO: begin
        op_wr = 1'b1; op_addr = base_q + STB_OFS; op_wdata = sword_q;
      end
      ST_WR_M: begin
        op_wr = 1'b1; op_addr = base_q + M_OFS; op_wdata = put_m(mword_q, m_q);
      end
      default: op_act = 1'b0;
    endcase
  end

  assign req = op_act && !pend_q && bm_idle;

  frac_bus_master #(.AW(ADDR_W), .DW(DATA_W)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req), .req_wr_i(op_wr), .req_addr_i(op_addr), .req_wdata_i(op_wdata),
    .idle_o(bm_idle), .done_o(bm_done), .rdata_o(bm_rdata),
    .addr_o(bus_addr_o), .read_o(bus_read_o), .write_o(bus_write_o),
    .wdata_o(bus_wdata_o), .rdata_i(bus_rdata_i), .rvalid_i(bus_rvalid_i),
    .waitreq_i(bus_waitreq_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      tgt_q   <= '0;
      cur_q   <= '0;
      nxt_q   <= '0;
      max_q   <= '0;
      lim_q   <= '0;
      m_q     <= '0;
      gap_q   <= '0;
      base_q  <= '0;
      kword_q <= '0;
      sword_q <= '0;
      mword_q <= '0;
      rst_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (req)          pend_q <= 1'b1;
      else if (bm_done) pend_q <= 1'b0;

      unique case (st_q)
        ST_IDLE: if (start_i) begin
          tgt_q  <= target_k_i;
          max_q  <= max_step_i;
          lim_q  <= reprog_lim_i;
          m_q    <= target_m_i;
          gap_q  <= min_gap_i;
          base_q <= reg_base(lane_i, pll_sel_i);
          st_q   <= ST_RD_K;
        end
        ST_RD_K: if (bm_done) begin
          kword_q <= bm_rdata;
          cur_q   <= bm_rdata[K_LSB +: K_W];
          st_q    <= ST_RD_S;
        end
        ST_RD_S: if (bm_done) begin
          sword_q <= bm_rdata & ~(DATA_W'(1) << STB_BIT);
          st_q    <= ST_PLAN;
        end
        ST_PLAN: begin
          if (plan_zero)     st_q <= ST_IDLE;
          else if (plan_big) st_q <= ST_RST_ON;
          else begin
            nxt_q <= plan_next;
            st_q  <= ST_WR_K;
          end
        end
        ST_WAIT:   if (tmr_done) st_q <= ST_PLAN;
        ST_WR_K: if (bm_done) begin
          kword_q <= put_k(kword_q, nxt_q);
          st_q    <= ST_STB_HI;
        end
        ST_STB_HI: if (bm_done) st_q <= ST_STB_LO;
        ST_STB_LO: if (bm_done) begin
          cur_q <= nxt_q;
          st_q  <= (nxt_q == tgt_q) ? ST_IDLE : ST_WAIT;
        end
        ST_RST_ON: begin
          rst_q <= 1'b1;
          st_q  <= ST_RP_K;
        end
        ST_RP_K: if (bm_done) begin
          kword_q <= put_k(kword_q, tgt_q);
          cur_q   <= tgt_q;
          st_q    <= ST_RD_M;
        end
        ST_RD_M: if (bm_done) begin
          mword_q <= bm_rdata;
          st_q    <= ST_WR_M;
        end
        ST_WR_M:   if (bm_done) st_q <= ST_RST_OFF;
        ST_RST_OFF: begin
          rst_q <= 1'b0;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign pll_rst_o = rst_q;
endmodule

// File: rtl/frac_ramp_ctrl_chk.sv
module frac_ramp_ctrl_chk #(
  parameter int unsigned AW    = 20,
  parameter int unsigned DW    = 32,
  parameter int unsigned GAP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [GAP_W-1:0] min_gap_i,
  input logic             busy_o,
  input logic             pll_rst_o,
  input logic [AW-1:0]    bus_addr_o,
  input logic             bus_read_o,
  input logic             bus_write_o,
  input logic [DW-1:0]    bus_wdata_o,
  input logic             bus_waitreq_i
);
  logic [GAP_W:0]   since_q;
  logic [GAP_W-1:0] gap_q;
  logic             have_q, stb_lo_acc, k_acc;

  assign stb_lo_acc = bus_write_o && !bus_waitreq_i &&
                      (bus_addr_o[3:0] == 4'hC) && !bus_wdata_o[17];
  assign k_acc      = bus_write_o && !bus_waitreq_i &&
                      (bus_addr_o[3:0] == 4'h0) && !pll_rst_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      gap_q   <= '0;
      have_q  <= 1'b0;
    end else begin
      if (start_i && !busy_o) begin
        gap_q  <= min_gap_i;
        have_q <= 1'b0;
      end else if (stb_lo_acc) begin
        have_q <= 1'b1;
      end
      if (stb_lo_acc)          since_q <= '0;
      else if (!(&since_q))    since_q <= since_q + 1'b1;
    end
  end

  assert_one_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_read_o && bus_write_o));

  assert_hold_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_read_o || bus_write_o) && bus_waitreq_i |=>
      $stable(bus_addr_o) && $stable(bus_wdata_o) &&
      $stable(bus_read_o) && $stable(bus_write_o));

  assert_quiet_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_read_o && !bus_write_o && !pll_rst_o);

  assert_rst_released_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !pll_rst_o);

  assert_no_commit_in_rst_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_write_o && pll_rst_o |-> !((bus_addr_o[3:0] == 4'hC) && bus_wdata_o[17]));

  assert_step_gap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    k_acc && have_q |-> since_q >= {1'b0, gap_q});
endmodule

bind frac_ramp_ctrl frac_ramp_ctrl_chk #(
  .AW(frac_ramp_pkg::ADDR_W), .DW(frac_ramp_pkg::DATA_W), .GAP_W(GAP_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .min_gap_i(min_gap_i),
  .busy_o(busy_o), .pll_rst_o(pll_rst_o), .bus_addr_o(bus_addr_o),
  .bus_read_o(bus_read_o), .bus_write_o(bus_write_o),
  .bus_wdata_o(bus_wdata_o), .bus_waitreq_i(bus_waitreq_i)
);

// File: tb/frac_ramp_ctrl_test.sv
module frac_ramp_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] S_INIT = 32'h1234_0056;
  localparam logic [31:0] M_INIT = 32'hABCD_E055;

  typedef struct packed {
    logic [1:0]  lane;
    logic [1:0]  pll;
    logic [21:0] init_k;
    logic [21:0] tgt_k;
    logic [21:0] step;
    logic [15:0] gap;
    logic [21:0] lim;
    logic [8:0]  m;
    logic        reprog;
    logic [7:0]  ncommit;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 22'd1000,    22'd1100,    22'd30,   16'd5,  22'd5000,  9'd39, 1'b0, 8'd4},
    '{2'd3, 2'd2, 22'd2097152, 22'd2097000, 22'd50,   16'd3,  22'd5000,  9'd40, 1'b0, 8'd4},
    '{2'd1, 2'd1, 22'd500,     22'd500,     22'd10,   16'd2,  22'd1000,  9'd41, 1'b0, 8'd0},
    '{2'd2, 2'd0, 22'd0,       22'd4000,    22'd4000, 16'd1,  22'd4000,  9'd42, 1'b0, 8'd1},
    '{2'd3, 2'd1, 22'd100000,  22'd3000000, 22'd1000, 16'd0,  22'd20000, 9'd43, 1'b1, 8'd0},
    '{2'd1, 2'd2, 22'd4194303, 22'd4194000, 22'd100,  16'd20, 22'd5000,  9'd44, 1'b0, 8'd4},
    '{2'd0, 2'd1, 22'd10,      22'd0,       22'd3,    16'd4,  22'd1000,  9'd45, 1'b0, 8'd4}
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [1:0]  lane_i = '0, pll_sel_i = '0;
  logic [21:0] target_k_i = '0, max_step_i = '0, reprog_lim_i = '0;
  logic [8:0]  target_m_i = '0;
  logic [15:0] min_gap_i = '0;
  logic        busy_o, pll_rst_o, bus_read_o, bus_write_o;
  logic [19:0] bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_rvalid_i = 1'b0;
  logic        bus_waitreq_i;

  frac_ramp_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .lane_i(lane_i),
    .pll_sel_i(pll_sel_i), .target_k_i(target_k_i), .target_m_i(target_m_i),
    .max_step_i(max_step_i), .min_gap_i(min_gap_i), .reprog_lim_i(reprog_lim_i),
    .busy_o(busy_o), .pll_rst_o(pll_rst_o), .bus_addr_o(bus_addr_o),
    .bus_read_o(bus_read_o), .bus_write_o(bus_write_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i), .bus_rvalid_i(bus_rvalid_i),
    .bus_waitreq_i(bus_waitreq_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // slave model state
  int          cyc = 0, commits, writes, step_viol, gap_viol, bad_addr, proto_viol, rst_strobe, last_s0;
  logic        rst_seen, stalled, clr = 1'b0;
  logic [19:0] st_addr, exp_base = '0;
  logic [31:0] kreg, sreg, mreg;
  logic [21:0] prev_k, v_init = '0, v_step = '0;
  int          v_gap = 0;
  int          tests = 0, fails = 0;
  logic        done_flag = 1'b0;

  assign bus_waitreq_i = (cyc % 3 == 1);

  function automatic logic [21:0] adiff(input logic [21:0] a, input logic [21:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    bus_rvalid_i <= 1'b0;
    if (clr) begin
      kreg <= {1'b1, v_init, 9'h1A5}; sreg <= S_INIT; mreg <= M_INIT;
      commits <= 0; writes <= 0; step_viol <= 0; gap_viol <= 0; bad_addr <= 0;
      proto_viol <= 0; rst_strobe <= 0; rst_seen <= 1'b0; stalled <= 1'b0;
      prev_k <= v_init; last_s0 <= 0; st_addr <= '0;
    end else begin
      if (pll_rst_o) rst_seen <= 1'b1;
      if (stalled && (bus_addr_o != st_addr || !(bus_read_o || bus_write_o)))
        proto_viol <= proto_viol + 1;
      if ((bus_read_o && bus_write_o)) proto_viol <= proto_viol + 1;
      stalled <= (bus_read_o || bus_write_o) && bus_waitreq_i;
      st_addr <= bus_addr_o;
      if ((bus_read_o || bus_write_o) && !bus_waitreq_i) begin
        if (bus_write_o) writes <= writes + 1;
        if (bus_addr_o == exp_base) begin
          if (bus_write_o) begin
            kreg <= bus_wdata_o;
            if (!pll_rst_o && commits != 0 && (cyc - last_s0) < v_gap) gap_viol <= gap_viol + 1;
          end else begin
            bus_rvalid_i <= 1'b1; bus_rdata_i <= kreg;
          end
        end else if (bus_addr_o == exp_base + 20'hC) begin
          if (bus_write_o) begin
            sreg <= bus_wdata_o;
            if (bus_wdata_o[17] && !sreg[17]) begin
              commits <= commits + 1;
              if (pll_rst_o) rst_strobe <= rst_strobe + 1;
              if (adiff(kreg[30:9], prev_k) > v_step) step_viol <= step_viol + 1;
              prev_k <= kreg[30:9];
            end
            if (!bus_wdata_o[17] && sreg[17]) last_s0 <= cyc;
          end else begin
            bus_rvalid_i <= 1'b1; bus_rdata_i <= sreg;
          end
        end else if (bus_addr_o == exp_base + 20'h4) begin
          if (bus_write_o) mreg <= bus_wdata_o;
          else begin bus_rvalid_i <= 1'b1; bus_rdata_i <= mreg; end
        end else begin
          bad_addr <= bad_addr + 1;
        end
      end
    end
  end

  always @(posedge clk_i) begin
    if (cyc > 150000 && !done_flag) begin
      $display("FAIL watchdog R8: actual=hung expected=idle");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input vec_t v);
    @(negedge clk_i);
    v_init = v.init_k; v_step = v.step; v_gap = int'(v.gap);
    exp_base = 20'h44000 + {3'b0, v.lane, 15'b0} + {10'b0, v.pll, 8'b0};
    lane_i = v.lane; pll_sel_i = v.pll; target_k_i = v.tgt_k; max_step_i = v.step;
    min_gap_i = v.gap; reprog_lim_i = v.lim; target_m_i = v.m;
    clr = 1'b1;
    @(negedge clk_i);
    clr = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk_i);
      if (!busy_o) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    bit ok;
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !pll_rst_o && !bus_read_o && !bus_write_o, "R1 in reset",
        {busy_o, pll_rst_o, bus_read_o, bus_write_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o && !pll_rst_o && !bus_read_o && !bus_write_o, "R1 after reset",
        {busy_o, pll_rst_o, bus_read_o, bus_write_o}, 0);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      longint d, expc;
      v = VECS[n];
      setup(v);
      pulse_start();
      chk(busy_o == 1'b1, "R8 busy after start", busy_o, 1);
      wait_idle(ok);
      chk(ok, "R8 run completes", ok, 1);
      d = longint'(adiff(v.tgt_k, v.init_k));
      expc = v.reprog ? 0 : (d + v.step - 1) / v.step;
      chk(kreg == {1'b1, v.tgt_k, 9'h1A5}, "R3 R5 final k word", kreg, {1'b1, v.tgt_k, 9'h1A5});
      chk(longint'(commits) == expc && commits == int'(v.ncommit), "R5 commit count", commits, expc);
      chk(step_viol == 0, "R5 step bound", step_viol, 0);
      chk(sreg == S_INIT, "R4 strobe word restored", sreg, S_INIT);
      chk(gap_viol == 0, "R6 inter-step gap", gap_viol, 0);
      chk(bad_addr == 0, "R2 address map", bad_addr, 0);
      chk(proto_viol == 0, "R9 bus protocol", proto_viol, 0);
      chk(rst_seen == v.reprog && !pll_rst_o, "R7 reset hold use", rst_seen, v.reprog);
      chk(rst_strobe == 0, "R7 no commit in reset", rst_strobe, 0);
      chk(mreg == (v.reprog ? {M_INIT[31:9], v.m} : M_INIT), "R7 M field",
          mreg, v.reprog ? {M_INIT[31:9], v.m} : M_INIT);
      if (d == 0) chk(writes == 0, "R10 no write on zero change", writes, 0);
    end

    // R8: start while busy is ignored
    setup(VECS[0]);
    pulse_start();
    repeat (15) @(negedge clk_i);
    target_k_i = 22'd9999; max_step_i = 22'd1;
    pulse_start();
    wait_idle(ok);
    chk(ok && kreg[30:9] == VECS[0].tgt_k, "R8 start while busy ignored",
        kreg[30:9], VECS[0].tgt_k);
    chk(commits == 4, "R8 commits unchanged by ignored start", commits, 4);

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule